// File: doc/BRIEF.md
# Receive Address Filter for Bit-Oriented Link Frames

This block sits behind a link-layer deframer that has already stripped flags and bit stuffing. It inspects the leading address bytes of each received frame and decides whether the frame goes on or is thrown away. A 3-bit mode input, sampled at start of frame, selects how many address bytes are examined and which byte positions are compared. Software programs two candidate values for the first (service) address byte and two for the second (terminal) address byte. Fixed broadcast values also match in the modes that allow them.

Bytes of a frame are held inside the block until the decision is known. An accepted frame is then released in order and without gaps, followed by a one-cycle end-of-frame marker. A rejected frame produces no output bytes at all. Each frame also yields one decision pulse, which carries the accept flag and a code naming the value that matched.

Top module: `hdlc_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `out_valid` and `out_eof` are low until a frame is driven.
- R2: Mode codes 000 and 010 compare the first byte only, against the terminal values 1 and 2. The broadcast byte 0xFF does not match in these modes.
- R3: Mode codes 001 and 011 compare two bytes. The first byte must match service value 1, service value 2 or the service broadcast. The second byte must match terminal value 1, terminal value 2 or 0xFF.
- R4: Service comparisons ignore bit 1 of the byte. The service broadcast therefore matches both 0xFC and 0xFE, and a programmed service value matches with bit 1 set or clear.
- R5: Mode code 101 accepts any first byte and compares the second byte against terminal value 1, terminal value 2 or 0xFF.
- R6: Mode code 111 compares only the first byte, against the service set including broadcast. Later bytes are not examined.
- R7: Mode code 110 accepts every frame, including a frame with no bytes. The match code is 0.
- R8: Mode code 100 discards every frame.
- R9: `match_src` encodes the match as 1 = value 1, 2 = value 2, 3 = broadcast, and 0 for a discard or for mode 110. The priority is value 1, then value 2, then broadcast. In two-byte modes the code comes from the last compared byte.
- R10: An accepted frame is output as every input byte in order on consecutive cycles, followed at once by a single `out_eof` pulse. A discarded frame produces no `out_valid` and no `out_eof`.
- R11: A frame that ends before all the address bytes its mode needs have arrived is discarded.
- R12: Exactly one `dec_valid` pulse comes out per frame. It appears in the cycle after the input that settles the decision. That input is `in_sof` for modes 100 and 110, otherwise the first failing compared byte, the last compared byte, or `in_eof` for a short frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 3 | Filter mode code, sampled with `in_sof` |
| sap1_i | input | 8 | Service address value 1 |
| sap2_i | input | 8 | Service address value 2 |
| tei1_i | input | 8 | Terminal address value 1 |
| tei2_i | input | 8 | Terminal address value 2 |
| in_sof | input | 1 | Start-of-frame strobe, in a cycle of its own |
| in_valid | input | 1 | Input byte strobe |
| in_data | input | 8 | Input byte |
| in_eof | input | 1 | End-of-frame strobe, in a cycle of its own |
| dec_valid | output | 1 | One-cycle decision pulse per frame |
| dec_accept | output | 1 | Decision: 1 accept, 0 discard |
| match_src | output | 2 | Match source code |
| out_valid | output | 1 | Released byte strobe |
| out_data | output | 8 | Released byte |
| out_eof | output | 1 | End-of-frame marker for an accepted frame |

## Verification
Each mode is driven with addresses that hit value 1, value 2 and the broadcast value, and with addresses that miss. These frames separate the per-mode value sets, for example 0xFF being refused in one-byte mode but taken in two-byte mode. They also confirm that the unchecked byte position really is ignored. Some first bytes have bit 1 flipped, and one case programs a value equal to the broadcast, which exposes the masked compare and the priority order. Short and empty frames, together with the reserved and pass-all codes, pin down when the decision is made. For every frame the bench checks the exact cycle of the decision pulse and that the released stream has no gaps.

// File: rtl/afl_pkg.sv
package afl_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_MAX = 2;

    localparam logic [DATA_W-1:0] SVC_BCAST = 8'hFC;
    localparam logic [DATA_W-1:0] TRM_BCAST = 8'hFF;
    localparam logic [DATA_W-1:0] CR_MASK   = 8'hFD;

    typedef enum logic [2:0] {
        MODE_ONE_A = 3'd0,
        MODE_TWO_A = 3'd1,
        MODE_ONE_B = 3'd2,
        MODE_TWO_B = 3'd3,
        MODE_RSVD  = 3'd4,
        MODE_LOW   = 3'd5,
        MODE_ALL   = 3'd6,
        MODE_HIGH  = 3'd7
    } mode_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ONE   = 2'd1,
        SRC_TWO   = 2'd2,
        SRC_BCAST = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PASS,
        ST_DROP
    } fstate_e;

    typedef struct packed {
        logic              eof;
        logic [DATA_W-1:0] data;
    } ent_t;

    // number of address bytes a mode must see before it can accept
    function automatic int need_bytes(mode_e m);
        case (m)
            MODE_ONE_A, MODE_ONE_B, MODE_HIGH: return 1;
            MODE_TWO_A, MODE_TWO_B, MODE_LOW:  return 2;
            default:                           return 0;
        endcase
    endfunction

    // service byte lookup, command/response bit masked out
    function automatic src_e svc_lookup(logic [DATA_W-1:0] b,
                                        logic [DATA_W-1:0] v1,
                                        logic [DATA_W-1:0] v2);
        if (((b ^ v1) & CR_MASK) == '0)             return SRC_ONE;
        if (((b ^ v2) & CR_MASK) == '0)             return SRC_TWO;
        if (((b ^ SVC_BCAST) & CR_MASK) == '0)      return SRC_BCAST;
        return SRC_NONE;
    endfunction

    function automatic src_e trm_lookup(logic [DATA_W-1:0] b,
                                        logic [DATA_W-1:0] v1,
                                        logic [DATA_W-1:0] v2,
                                        logic              allow_bc);
        if (b == v1)                    return SRC_ONE;
        if (b == v2)                    return SRC_TWO;
        if (allow_bc && b == TRM_BCAST) return SRC_BCAST;
        return SRC_NONE;
    endfunction

endpackage

// File: rtl/afl_matcher.sv
module afl_matcher
    import afl_pkg::*;
(
    input  mode_e             mode,
    input  logic              second,
    input  logic [DATA_W-1:0] bval,
    input  logic [DATA_W-1:0] svc1,
    input  logic [DATA_W-1:0] svc2,
    input  logic [DATA_W-1:0] trm1,
    input  logic [DATA_W-1:0] trm2,
    output logic              ok,
    output src_e              src
);

    logic skip;

    always_comb begin
        src  = SRC_NONE;
        skip = 1'b0;
        case (mode)
            MODE_ONE_A, MODE_ONE_B:
                src = trm_lookup(bval, trm1, trm2, 1'b0);
            MODE_TWO_A, MODE_TWO_B:
                src = second ? trm_lookup(bval, trm1, trm2, 1'b1)
                             : svc_lookup(bval, svc1, svc2);
            MODE_LOW: begin
                if (second) src = trm_lookup(bval, trm1, trm2, 1'b1);
                else        skip = 1'b1;
            end
            MODE_HIGH:
                src = svc_lookup(bval, svc1, svc2);
            default:
                src = SRC_NONE;
        endcase
        ok = (src != SRC_NONE) || skip;
    end

endmodule

// File: rtl/afl_hold_fifo.sv
module afl_hold_fifo
    import afl_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  ent_t push_ent,
    input  logic commit,
    input  logic rewind,
    output logic pop_valid,
    output ent_t pop_ent
);

    localparam int PW = $clog2(DEPTH);

    ent_t        mem [DEPTH];
    logic [PW:0] wr_p, cm_p, rd_p;
    logic        do_push;

    assign do_push = push && !rewind;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_p[PW-1:0]] <= push_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p      <= '0;
            cm_p      <= '0;
            rd_p      <= '0;
            pop_valid <= 1'b0;
            pop_ent   <= '0;
        end else begin
            if (rewind)       wr_p <= cm_p;
            else if (do_push) wr_p <= wr_p + 1'b1;

            if (commit && !rewind) cm_p <= do_push ? wr_p + 1'b1 : wr_p;

            pop_valid <= (rd_p != cm_p);
            pop_ent   <= mem[rd_p[PW-1:0]];
            if (rd_p != cm_p) rd_p <= rd_p + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import afl_pkg::*;
#(
    parameter int HOLD_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        mode_i,
    input  logic [DATA_W-1:0] sap1_i,
    input  logic [DATA_W-1:0] sap2_i,
    input  logic [DATA_W-1:0] tei1_i,
    input  logic [DATA_W-1:0] tei2_i,
    input  logic              in_sof,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_eof,
    output logic              dec_valid,
    output logic              dec_accept,
    output logic [1:0]        match_src,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_eof
);

    localparam int CW = $clog2(ADDR_MAX + 1);

    fstate_e       st;
    mode_e         mode_q;
    logic [CW-1:0] cnt;
    logic          m_ok;
    src_e          m_src;
    logic          is_last;
    mode_e         mode_now;

    logic push, commit, rewind, pop_v;
    ent_t push_ent, pop_e;

    assign mode_now = mode_e'(mode_i);
    assign is_last  = (int'(cnt) == need_bytes(mode_q) - 1);

    afl_matcher u_match (
        .mode   (mode_q),
        .second (cnt != '0),
        .bval   (in_data),
        .svc1   (sap1_i),
        .svc2   (sap2_i),
        .trm1   (tei1_i),
        .trm2   (tei2_i),
        .ok     (m_ok),
        .src    (m_src)
    );

    always_comb begin
        push     = 1'b0;
        commit   = 1'b0;
        rewind   = 1'b0;
        push_ent = '{eof: in_eof, data: in_valid ? in_data : '0};
        if (in_sof) begin
            rewind = (st == ST_ADDR);
        end else begin
            case (st)
                ST_ADDR: begin
                    if (in_valid && m_ok) begin
                        push   = 1'b1;
                        commit = is_last;
                    end
                    rewind = (in_valid && !m_ok) || in_eof;
                end
                ST_PASS: begin
                    push   = in_valid || in_eof;
                    commit = in_valid || in_eof;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            mode_q     <= MODE_ONE_A;
            cnt        <= '0;
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            match_src  <= SRC_NONE;
        end else begin
            dec_valid <= 1'b0;
            if (in_sof) begin
                mode_q <= mode_now;
                cnt    <= '0;
                if (need_bytes(mode_now) == 0) begin
                    dec_valid  <= 1'b1;
                    dec_accept <= (mode_now == MODE_ALL);
                    match_src  <= SRC_NONE;
                    st         <= (mode_now == MODE_ALL) ? ST_PASS : ST_DROP;
                end else begin
                    st <= ST_ADDR;
                end
            end else begin
                case (st)
                    ST_ADDR: begin
                        if (in_valid) begin
                            if (!m_ok) begin
                                dec_valid  <= 1'b1;
                                dec_accept <= 1'b0;
                                match_src  <= SRC_NONE;
                                st         <= ST_DROP;
                            end else if (is_last) begin
                                dec_valid  <= 1'b1;
                                dec_accept <= 1'b1;
                                match_src  <= m_src;
                                st         <= ST_PASS;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end else if (in_eof) begin
                            dec_valid  <= 1'b1;
                            dec_accept <= 1'b0;
                            match_src  <= SRC_NONE;
                            st         <= ST_IDLE;
                        end
                    end
                    ST_PASS, ST_DROP: if (in_eof) st <= ST_IDLE;
                    default: ;
                endcase
            end
        end
    end

    afl_hold_fifo #(.DEPTH(HOLD_DEPTH)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_ent  (push_ent),
        .commit    (commit),
        .rewind    (rewind),
        .pop_valid (pop_v),
        .pop_ent   (pop_e)
    );

    assign out_valid = pop_v && !pop_e.eof;
    assign out_eof   = pop_v && pop_e.eof;
    assign out_data  = pop_e.data;

endmodule

// File: rtl/afl_chk.sv
module afl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_i,
    input logic       dec_valid,
    input logic       dec_accept,
    input logic [1:0] match_src,
    input logic       out_valid,
    input logic       out_eof
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_eof && !dec_valid));

    // R8
    rsvd_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(mode_i) == 3'b100) |-> !dec_accept);

    // R7
    pass_all_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && $past(mode_i) == 3'b110) |-> (dec_accept && match_src == 2'd0));

    // R2
    one_byte_no_bcast_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && ($past(mode_i) == 3'b000 || $past(mode_i) == 3'b010))
            |-> match_src != 2'd3);

    // R9
    drop_src_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && !dec_accept) |-> match_src == 2'd0);

endmodule

bind hdlc_addr_filter afl_chk u_afl_chk (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .dec_valid  (dec_valid),
    .dec_accept (dec_accept),
    .match_src  (match_src),
    .out_valid  (out_valid),
    .out_eof    (out_eof)
);

// File: tb/tb_hdlc_addr_filter.sv
module tb_hdlc_addr_filter;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] mode_i = 3'd0;
    logic [7:0] sap1_i = 8'h20, sap2_i = 8'h40, tei1_i = 8'h42, tei2_i = 8'h84;
    logic       in_sof = 1'b0, in_valid = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       dec_valid, dec_accept, out_valid, out_eof;
    logic [1:0] match_src;
    logic [7:0] out_data;

    int checks = 0;
    int failures = 0;

    int cyc = 0;
    int dec_n, dec_cyc, ocnt, eof_n;
    logic dec_acc;
    logic [1:0] dec_src;
    logic gap, prev_out;
    logic [7:0] obuf [8];

    always #10 clk = ~clk;

    hdlc_addr_filter dut (
        .clk(clk), .rst(rst), .mode_i(mode_i),
        .sap1_i(sap1_i), .sap2_i(sap2_i), .tei1_i(tei1_i), .tei2_i(tei2_i),
        .in_sof(in_sof), .in_valid(in_valid), .in_data(in_data), .in_eof(in_eof),
        .dec_valid(dec_valid), .dec_accept(dec_accept), .match_src(match_src),
        .out_valid(out_valid), .out_data(out_data), .out_eof(out_eof)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (dec_valid) begin
            dec_n   = dec_n + 1;
            dec_cyc = cyc;
            dec_acc = dec_accept;
            dec_src = match_src;
        end
        if (out_valid) begin
            if (ocnt < 8) obuf[ocnt] = out_data;
            if (ocnt > 0 && !prev_out) gap = 1'b1;
            ocnt = ocnt + 1;
        end
        if (out_eof) begin
            if (ocnt > 0 && !prev_out) gap = 1'b1;
            eof_n = eof_n + 1;
        end
        prev_out = out_valid;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // step: 0 = sof, k = byte k-1, n+1 = eof
    task automatic run_frame(input logic [2:0] m, input int n,
                             input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input bit exp_acc,
                             input logic [1:0] exp_src, input int step,
                             input string rq);
        logic [7:0] b [3];
        int c0;
        b[0] = b0; b[1] = b1; b[2] = b2;
        @(posedge clk); #1;
        mode_i = m;
        dec_n = 0; ocnt = 0; eof_n = 0; gap = 1'b0; dec_cyc = -1;
        dec_acc = 1'b0; dec_src = 2'd0;
        @(posedge clk); #1;
        c0 = cyc;
        in_sof = 1'b1;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            in_sof = 1'b0; in_valid = 1'b1; in_data = b[k];
        end
        @(posedge clk); #1;
        in_sof = 1'b0; in_valid = 1'b0; in_eof = 1'b1;
        @(posedge clk); #1;
        in_eof = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        check(dec_n == 1, "R12", "decision count", dec_n, 1);
        check(dec_cyc == c0 + step + 2, "R12", "decision cycle", dec_cyc - c0, step + 2);
        check(dec_acc == exp_acc, rq, "accept", int'(dec_acc), int'(exp_acc));
        check(dec_src == exp_src, rq, "match source (R9)", int'(dec_src), int'(exp_src));
        if (exp_acc) begin
            check(ocnt == n, "R10", "released byte count", ocnt, n);
            for (int k = 0; k < n; k++)
                check(obuf[k] == b[k], "R10", "released byte", int'(obuf[k]), int'(b[k]));
            check(eof_n == 1, "R10", "end marker count", eof_n, 1);
            check(!gap, "R10", "gap in stream", int'(gap), 0);
        end else begin
            check(ocnt == 0 && eof_n == 0, "R10", "output from discarded frame",
                  ocnt + eof_n, 0);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(!dec_valid && !out_valid && !out_eof, "R1", "outputs after reset",
              int'({dec_valid, out_valid, out_eof}), 0);
    endtask

    task automatic t_one_byte();
        run_frame(3'd0, 3, 8'h42, 8'h01, 8'h02, 1, 2'd1, 1, "R2");
        run_frame(3'd0, 2, 8'h84, 8'h33, 8'h00, 1, 2'd2, 1, "R2");
        run_frame(3'd0, 2, 8'hFF, 8'h33, 8'h00, 0, 2'd0, 1, "R2");
        run_frame(3'd2, 1, 8'h84, 8'h00, 8'h00, 1, 2'd2, 1, "R2");
    endtask

    task automatic t_two_byte();
        run_frame(3'd1, 3, 8'h20, 8'h42, 8'hAA, 1, 2'd1, 2, "R3");
        run_frame(3'd1, 2, 8'h10, 8'h42, 8'h00, 0, 2'd0, 1, "R3");
        run_frame(3'd1, 2, 8'h20, 8'h77, 8'h00, 0, 2'd0, 2, "R3");
        run_frame(3'd3, 2, 8'h40, 8'hFF, 8'h00, 1, 2'd3, 2, "R3");
    endtask

    task automatic t_cr_bit();
        run_frame(3'd1, 2, 8'hFC, 8'hFF, 8'h00, 1, 2'd3, 2, "R4");
        run_frame(3'd3, 3, 8'hFE, 8'h84, 8'h05, 1, 2'd2, 2, "R4");
        run_frame(3'd3, 2, 8'h22, 8'h42, 8'h00, 1, 2'd1, 2, "R4");
    endtask

    task automatic t_short();
        run_frame(3'd1, 1, 8'h20, 8'h00, 8'h00, 0, 2'd0, 2, "R11");
        run_frame(3'd0, 0, 8'h00, 8'h00, 8'h00, 0, 2'd0, 1, "R11");
        run_frame(3'd5, 1, 8'h99, 8'h00, 8'h00, 0, 2'd0, 2, "R11");
    endtask

    task automatic t_low_only();
        run_frame(3'd5, 3, 8'h99, 8'h84, 8'h11, 1, 2'd2, 2, "R5");
        run_frame(3'd5, 2, 8'h99, 8'h77, 8'h00, 0, 2'd0, 2, "R5");
        run_frame(3'd5, 2, 8'h10, 8'hFF, 8'h00, 1, 2'd3, 2, "R5");
    endtask

    task automatic t_high_only();
        run_frame(3'd7, 2, 8'h42, 8'h00, 8'h00, 1, 2'd2, 1, "R6");
        run_frame(3'd7, 1, 8'hFE, 8'h00, 8'h00, 1, 2'd3, 1, "R6");
        run_frame(3'd7, 2, 8'h55, 8'h42, 8'h00, 0, 2'd0, 1, "R6");
    endtask

    task automatic t_pass_and_reserved();
        run_frame(3'd6, 3, 8'h01, 8'h02, 8'h03, 1, 2'd0, 0, "R7");
        run_frame(3'd6, 0, 8'h00, 8'h00, 8'h00, 1, 2'd0, 0, "R7");
        run_frame(3'd4, 2, 8'h20, 8'h42, 8'h00, 0, 2'd0, 0, "R8");
    endtask

    task automatic t_priority();
        @(posedge clk); #1 tei2_i = 8'hFF;
        run_frame(3'd1, 2, 8'h40, 8'hFF, 8'h00, 1, 2'd2, 2, "R9");
        @(posedge clk); #1 tei1_i = 8'h84; tei2_i = 8'h84;
        run_frame(3'd0, 1, 8'h84, 8'h00, 8'h00, 1, 2'd1, 1, "R9");
        @(posedge clk); #1 tei1_i = 8'h42;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_one_byte();
        t_two_byte();
        t_cr_bit();
        t_short();
        t_low_only();
        t_high_only();
        t_pass_and_reserved();
        t_priority();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule